// File: doc/BRIEF.md
# SPI Nonvolatile Byte Array Write Controller

This block is a serial slave in SPI mode 0 that sits in front of a small byte-wide register file standing in for a nonvolatile array. The bus master pulls chip select low and shifts an 8-bit opcode in MSB first. Depending on the opcode, the block arms a write-enable latch, returns the status byte, stores a write of up to one page, updates the protection bits, or returns array data. A write is held in a page buffer and copied into the array only at the end of an internal write cycle of fixed length. The bus master polls the status byte to learn when that cycle has finished.

All serial inputs are brought into the system clock domain by a synchroniser, and every decision is made in that domain. The serial clock must run at no more than a quarter of the system clock rate. SO is handed to a pad as a data bit plus an output enable. The enable is high only while the block is returning status or array data.

Top module: `spi_eeprom_wctl`

## Requirements
- R1: After reset the status byte reads 0x00, SO is not driven, and every array byte reads 0xFF.
- R2: The write-enable opcode 0x06 sets WEL only when chip select rises after exactly those 8 bits. A rise after a partial opcode, or after further bytes in the same transaction, leaves WEL unchanged.
- R3: The page-write opcode 0x02 is ignored while WEL=0: no write cycle starts and the array is unchanged.
- R4: A write transaction is opcode 0x02, then an address byte, then data bytes, all sent MSB first. After the cycle each data byte appears at consecutive addresses starting at the given address.
- R5: The write address wraps from low bits 111 back to 000 of the same 8-byte page. A later byte overwrites an earlier one at the same location, and nothing lands outside the page.
- R6: A write is committed only when chip select rises directly after bit 0 of a complete data byte. A rise at any other bit drops the write, leaves the array unchanged and keeps WIP=0.
- R7: The status opcode 0x05 returns {0000, BP1, BP0, WEL, WIP}, with WIP in bit 0. The byte is reloaded for every further byte clocked, and it stays readable while a cycle runs, showing WIP=1.
- R8: The read opcode 0x03 followed by an address returns consecutive array bytes. While WIP=1 a read is refused, and SO stays undriven for the whole transaction.
- R9: A committed write holds WIP=1 for TWC_CYC system clocks. After that, WIP and WEL are both 0 and the new data is in the array.
- R10: The opcode 0x01, sent with WEL=1, loads data bits 3:2 into BP1:BP0 and clears WEL. BP=01 protects the top quarter of the array, BP=10 the top half and BP=11 all of it. A write to a protected page starts no cycle and leaves the array unchanged.
- R11: SI is sampled on rising SCK and SO changes on falling SCK. SO is undriven outside status or data return, and it is never driven during a write transaction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, mode 0 |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out, valid while so_oe_o is high |
| so_oe_o | output | 1 | Output enable for the SO pad |

## Verification
Properties are checked on every cycle:
- WEL is only ever raised on a chip-select rise.
- A write cycle starts only while no cycle is running, and WIP rises only from that start.
- WEL is clear after a cycle ends.
- Every received byte lines up with a bit-count boundary.
- SO is released whenever chip select is high.

The effects of the transaction framing can only be shown by the bench scenarios, which read results back over the serial port. These cover a partial or overlong enable, an abort in mid-byte, page wrap with overwrite, protected-region drops, and a refused read during the cycle.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [3:0] {
    ST_CMD, ST_WREN, ST_STAT, ST_WADDR, ST_WDATA,
    ST_WSR, ST_WSRD, ST_RADDR, ST_RDATA, ST_IGN
  } cmd_st_e;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] ff_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q[s] <= RST_VAL;
      else if (s == 0) ff_q[s] <= d_i;
      else ff_q[s] <= ff_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/spi_ee_shift.sv
module spi_ee_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_n_s_i,
  input  logic       sck_s_i,
  input  logic       si_s_i,
  input  logic       tx_load_i,
  input  logic [7:0] tx_data_i,
  input  logic       tx_en_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       cs_rise_o,
  output logic       bnd_o,
  output logic       so_o,
  output logic       so_oe_o
);
  logic       sck_d_q, cs_d_q;
  logic [2:0] bit_cnt_q;
  logic [6:0] rx_q;
  logic [7:0] tx_q;
  logic       sck_rise, sck_fall;

  assign sck_rise  = ~cs_n_s_i & sck_s_i & ~sck_d_q;
  assign sck_fall  = ~cs_n_s_i & ~sck_s_i & sck_d_q;
  assign cs_rise_o = cs_n_s_i & ~cs_d_q;
  assign bnd_o     = (bit_cnt_q == 3'd0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d_q    <= 1'b0;
      cs_d_q     <= 1'b1;
      bit_cnt_q  <= '0;
      rx_q       <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
      tx_q       <= '0;
      so_o       <= 1'b0;
      so_oe_o    <= 1'b0;
    end else begin
      sck_d_q    <= sck_s_i;
      cs_d_q     <= cs_n_s_i;
      byte_vld_o <= 1'b0;
      if (cs_n_s_i) begin
        bit_cnt_q <= '0;
        so_oe_o   <= 1'b0;
      end else if (sck_rise) begin
        rx_q      <= {rx_q[5:0], si_s_i};
        bit_cnt_q <= bit_cnt_q + 3'd1;
        if (bit_cnt_q == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {rx_q, si_s_i};
        end
      end
      if (tx_load_i) begin
        tx_q <= tx_data_i;
      end else if (sck_fall) begin
        so_o    <= tx_q[7];
        tx_q    <= {tx_q[6:0], 1'b0};
        so_oe_o <= tx_en_i;
      end
    end
  end

  // R11
  oe_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !so_oe_o);
  // R6
  byte_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> bit_cnt_q == 3'd0);
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int ADDR_W  = 8,
  parameter int PAGE_W  = 3,
  parameter int TWC_CYC = 4000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              addr_vld_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              dat_vld_i,
  input  logic [7:0]        dat_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              wip_o,
  output logic              done_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int CNT_W  = $clog2(TWC_CYC + 1);

  logic [7:0]             mem_q  [DEPTH];
  logic [7:0]             buf_q  [PAGE_N];
  logic [PAGE_N-1:0]      mask_q;
  logic [ADDR_W-PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0]      off_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   wip_q;
  logic                   commit;

  assign commit    = wip_q && (cnt_q == '0);
  assign wip_o     = wip_q;
  assign rd_data_o = mem_q[rd_addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      page_q <= '0;
      off_q  <= '0;
      for (int i = 0; i < PAGE_N; i++) buf_q[i] <= '0;
    end else begin
      if (clr_i) mask_q <= '0;
      if (addr_vld_i) begin
        page_q <= addr_i[ADDR_W-1:PAGE_W];
        off_q  <= addr_i[PAGE_W-1:0];
      end
      if (dat_vld_i) begin
        buf_q[off_q]  <= dat_i;
        mask_q[off_q] <= 1'b1;
        off_q         <= off_q + 1'b1;  // wraps inside the page
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wip_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        cnt_q <= CNT_W'(TWC_CYC - 1);
        wip_q <= 1'b1;
      end else if (wip_q) begin
        if (cnt_q == '0) begin
          wip_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (commit) begin
      for (int i = 0; i < PAGE_N; i++)
        if (mask_q[i]) mem_q[{page_q, PAGE_W'(i)}] <= buf_q[i];
    end
  end

  // R9
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !wip_q);
  // R9
  wip_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> $past(start_i));
endmodule

// File: rtl/spi_eeprom_wctl.sv
module spi_eeprom_wctl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int PAGE_W      = 3,
  parameter int TWC_CYC     = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic si_i,
  output logic so_o,
  output logic so_oe_o
);
  logic cs_s, sck_s, si_s;
  logic byte_vld, cs_rise, bnd;
  logic [7:0] rx_byte;
  logic tx_load, tx_en, clr, addr_vld, dat_vld, wr_start, wip, done;
  logic [7:0] tx_data, rd_data, status;
  logic [ADDR_W-1:0] rd_addr, rd_ptr_q;
  cmd_st_e state_q, state_d;
  logic wel_q, got_dat_q;
  logic [1:0] bp_q, bp_pend_q, hi_q;

  spi_ee_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({cs_ni, sck_i, si_i}), .q_o({cs_s, sck_s, si_s}));

  spi_ee_shift u_shift (
    .clk_i, .rst_ni, .cs_n_s_i(cs_s), .sck_s_i(sck_s), .si_s_i(si_s),
    .tx_load_i(tx_load), .tx_data_i(tx_data), .tx_en_i(tx_en),
    .byte_vld_o(byte_vld), .byte_o(rx_byte), .cs_rise_o(cs_rise),
    .bnd_o(bnd), .so_o, .so_oe_o);

  spi_ee_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .TWC_CYC(TWC_CYC)) u_store (
    .clk_i, .rst_ni, .clr_i(clr), .addr_vld_i(addr_vld),
    .addr_i(rx_byte[ADDR_W-1:0]), .dat_vld_i(dat_vld), .dat_i(rx_byte),
    .start_i(wr_start), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .wip_o(wip), .done_o(done));

  function automatic logic prot_f(input logic [1:0] bp, input logic [1:0] hi);
    case (bp)
      2'b01:   prot_f = &hi;
      2'b10:   prot_f = hi[1];
      2'b11:   prot_f = 1'b1;
      default: prot_f = 1'b0;
    endcase
  endfunction

  assign status   = {4'b0000, bp_q, wel_q, wip};
  assign tx_en    = (state_q == ST_STAT) || (state_q == ST_RDATA);
  assign wr_start = cs_rise && bnd && (state_q == ST_WDATA) && got_dat_q &&
                    !prot_f(bp_q, hi_q);

  always_comb begin
    state_d  = state_q;
    tx_load  = 1'b0;
    tx_data  = status;
    clr      = 1'b0;
    addr_vld = 1'b0;
    dat_vld  = 1'b0;
    rd_addr  = rd_ptr_q;
    if (cs_s) begin
      state_d = ST_CMD;
    end else if (byte_vld) begin
      case (state_q)
        ST_CMD: begin
          case (rx_byte)
            OP_WREN: state_d = wip ? ST_IGN : ST_WREN;
            OP_RDSR: begin state_d = ST_STAT; tx_load = 1'b1; end
            OP_WRITE: begin
              if (wel_q && !wip) begin state_d = ST_WADDR; clr = 1'b1; end
              else state_d = ST_IGN;
            end
            OP_WRSR: state_d = (wel_q && !wip) ? ST_WSR : ST_IGN;
            OP_READ: state_d = wip ? ST_IGN : ST_RADDR;
            default: state_d = ST_IGN;
          endcase
        end
        ST_STAT:  tx_load = 1'b1;
        ST_WADDR: begin addr_vld = 1'b1; state_d = ST_WDATA; end
        ST_WDATA: dat_vld = 1'b1;
        ST_WSR:   state_d = ST_WSRD;
        ST_RADDR: begin
          rd_addr = rx_byte[ADDR_W-1:0];
          tx_load = 1'b1;
          tx_data = rd_data;
          state_d = ST_RDATA;
        end
        ST_RDATA: begin tx_load = 1'b1; tx_data = rd_data; end
        default:  state_d = ST_IGN;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      wel_q     <= 1'b0;
      bp_q      <= '0;
      bp_pend_q <= '0;
      hi_q      <= '0;
      got_dat_q <= 1'b0;
      rd_ptr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (addr_vld) hi_q <= rx_byte[ADDR_W-1 -: 2];
      if (clr) got_dat_q <= 1'b0;
      else if (dat_vld) got_dat_q <= 1'b1;
      if (byte_vld && (state_q == ST_RADDR || state_q == ST_RDATA))
        rd_ptr_q <= rd_addr + 1'b1;
      if (byte_vld && state_q == ST_WSR) bp_pend_q <= rx_byte[3:2];
      if (done) begin
        wel_q <= 1'b0;
      end else if (cs_rise && bnd) begin
        if (state_q == ST_WREN) wel_q <= 1'b1;
        if (state_q == ST_WSRD) begin
          bp_q  <= bp_pend_q;
          wel_q <= 1'b0;
        end
      end
    end
  end

  // R2
  wel_set_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_q) |-> $past(cs_rise));
  // R9
  wel_clr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !wel_q);
endmodule

// File: tb/tb_spi_eeprom_wctl.sv
module tb_spi_eeprom_wctl;
  localparam int TWC = 600;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic so, so_oe;
  int n_chk = 0, n_fail = 0, oe_cnt = 0, nb = 0;
  logic [7:0] sh = '0;
  logic [7:0] mdl [256];
  logic [7:0] wbuf [16];
  logic [7:0] exp_q [$];
  string tag_q [$];

  always #10 clk = ~clk;

  spi_eeprom_wctl #(.TWC_CYC(TWC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .so_o(so), .so_oe_o(so_oe));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) if (so_oe) oe_cnt++;

  // monitor: assemble SO bytes on rising SCK and compare with the scoreboard
  always @(posedge sck or posedge cs_n) begin
    if (cs_n) nb = 0;
    else if (so_oe) begin
      sh = {sh[6:0], so};
      nb++;
      if (nb == 8) begin
        nb = 0;
        if (exp_q.size() == 0) chk(1'b0, "R11 unexpected SO byte", sh, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(sh == e, t, sh, e);
        end
      end
    end
  end

  task automatic bit_x(input logic b);
    @(negedge clk) si = b;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) bit_x(v[i]);
  endtask

  task automatic cs_lo();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_hi();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    chk(so_oe == 1'b0, "R11 SO released", so_oe, 0);
  endtask

  task automatic push(input logic [7:0] v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic rdsr(input logic [7:0] e, input string t, input int n = 1);
    for (int i = 0; i < n; i++) push(e, t);
    cs_lo();
    byte_x(8'h05);
    for (int i = 0; i < n; i++) byte_x(8'h00);
    cs_hi();
  endtask

  task automatic rd(input logic [7:0] a, input int n, input string t);
    for (int i = 0; i < n; i++) push(mdl[8'(a + i)], t);
    cs_lo();
    byte_x(8'h03);
    byte_x(a);
    for (int i = 0; i < n; i++) byte_x(8'h00);
    cs_hi();
  endtask

  task automatic rd_refused(input logic [7:0] a);
    int s;
    s = oe_cnt;
    cs_lo();
    byte_x(8'h03);
    byte_x(a);
    byte_x(8'h00);
    byte_x(8'h00);
    cs_hi();
    chk(oe_cnt == s, "R8 read refused during cycle", oe_cnt - s, 0);
  endtask

  task automatic wren();
    cs_lo();
    byte_x(8'h06);
    cs_hi();
  endtask

  task automatic wrsr(input logic [7:0] v);
    cs_lo();
    byte_x(8'h01);
    byte_x(v);
    cs_hi();
  endtask

  task automatic wr(input logic [7:0] a, input int n, input int extra_bits = 0);
    int s;
    s = oe_cnt;
    cs_lo();
    byte_x(8'h02);
    byte_x(a);
    for (int i = 0; i < n; i++) byte_x(wbuf[i]);
    for (int i = 0; i < extra_bits; i++) bit_x(1'b1);
    cs_hi();
    chk(oe_cnt == s, "R11 SO idle in write", oe_cnt - s, 0);
  endtask

  task automatic mdl_apply(input logic [7:0] a, input int n);
    for (int i = 0; i < n; i++) mdl[{a[7:3], 3'(a[2:0] + i)}] = wbuf[i];
  endtask

  task automatic wait_cycle();
    repeat (TWC + 50) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mdl[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(so_oe == 1'b0, "R1 SO idle after reset", so_oe, 0);
    rdsr(8'h00, "R1 reset status");
    rd(8'h10, 2, "R1 erased array");

    // R3 write without latch
    wbuf[0] = 8'hAA;
    wr(8'h10, 1);
    wait_cycle();
    rdsr(8'h00, "R3 no cycle without WEL");
    rd(8'h10, 1, "R3 array unchanged");

    // R2 partial opcode, opcode followed by more bytes, then a proper enable
    cs_lo();
    for (int i = 0; i < 7; i++) bit_x(i == 5 || i == 6);
    cs_hi();
    rdsr(8'h00, "R2 partial enable ignored");
    cs_lo();
    byte_x(8'h06); byte_x(8'h02); byte_x(8'h10); byte_x(8'hAA);
    cs_hi();
    wait_cycle();
    rdsr(8'h00, "R2 enable without CS rise ignored");
    rd(8'h10, 1, "R2 array unchanged");
    wren();
    rdsr(8'h02, "R2 WEL set");

    // R4 three-byte write, R7/R8 during cycle, R9 end of cycle
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr(8'h10, 3);
    mdl_apply(8'h10, 3);
    rdsr(8'h03, "R7 status during cycle", 2);
    rd_refused(8'h10);
    wait_cycle();
    rdsr(8'h00, "R9 WIP and WEL clear after cycle");
    rd(8'h10, 3, "R4 data committed");

    // R5 wrap inside page with overwrite
    wren();
    for (int i = 0; i < 10; i++) wbuf[i] = 8'hA0 + 8'(i);
    wr(8'h1E, 10);
    wait_cycle();
    for (int i = 0; i < 8; i++) mdl[8'h18 + i] = wbuf[(i + 10 - 8 + 8 - 6) % 10];
    mdl[8'h18] = 8'hA2; mdl[8'h19] = 8'hA3; mdl[8'h1A] = 8'hA4; mdl[8'h1B] = 8'hA5;
    mdl[8'h1C] = 8'hA6; mdl[8'h1D] = 8'hA7; mdl[8'h1E] = 8'hA8; mdl[8'h1F] = 8'hA9;
    rd(8'h18, 8, "R5 page wrap overwrite");
    rd(8'h20, 1, "R5 no spill to next page");

    // R6 chip select rise in mid byte
    wren();
    wbuf[0] = 8'h55;
    wr(8'h30, 1, 3);
    rdsr(8'h02, "R6 aborted write no WIP");
    rd(8'h30, 1, "R6 array unchanged");

    // R10 protection of top quarter (BP0)
    wrsr(8'h04);
    rdsr(8'h04, "R10 BP0 set and WEL cleared");
    wren();
    wbuf[0] = 8'h77;
    wr(8'hF0, 1);
    rdsr(8'h06, "R10 protected write starts no cycle");
    wait_cycle();
    rd(8'hF0, 1, "R10 protected page unchanged");
    wbuf[0] = 8'h66;
    wr(8'h40, 1);
    mdl_apply(8'h40, 1);
    wait_cycle();
    rdsr(8'h04, "R10 unprotected write done");
    rd(8'h40, 1, "R10 unprotected data");

    // R10 protection of top half (BP1)
    wren();
    wrsr(8'h08);
    wren();
    wbuf[0] = 8'h99;
    wr(8'h80, 1);
    wait_cycle();
    rdsr(8'h0A, "R10 BP1 field and no cycle");
    rd(8'h80, 1, "R10 upper half unchanged");

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all expected SO bytes seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule